// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the sequence of column addresses for one data burst of a synchronous DRAM. A start strobe captures the start column, a decoded burst-length code and an ordering bit. From the next cycle on, the block emits one column per enabled clock until the burst is complete, is stopped, or is replaced by a new start. Row and bank selection, and the programming of the length and ordering fields, are handled elsewhere.

Two orderings are supported. In sequential ordering the low address bits inside the burst block count upward and wrap around, while the bits above the block stay fixed. In interleaved ordering the low bits are the start bits XORed with the beat number. Sequential ordering also has an open-ended page mode. This mode runs over the whole column space, wraps from the top column to zero, and never flags a final beat. A clock-enable input freezes the sequencer in place. Reserved length codes give a single-beat burst and raise an error flag.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After reset, `beat_valid`, `beat_last` and `len_err` are low and `col` is zero.
- R2: When `cke` and `start` are both high at a clock edge, the next cycle shows `beat_valid` high and `col` equal to the captured `start_col` (beat 0). Each later edge with `cke` high advances the burst by one beat.
- R3: Length codes on `len_code` are 3'b000 = 1 beat, 3'b001 = 2 beats, 3'b010 = 4 beats and 3'b011 = 8 beats. `beat_valid` stays high for exactly that many enabled cycles and then goes low.
- R4: With `burst_il` = 0 and a burst of length L, beat k has the bits above log2(L) taken from the start column. Its low log2(L) bits equal (start + k) mod L.
- R5: With `burst_il` = 1 and a burst of length L, beat k has the bits above log2(L) taken from the start column. Its low log2(L) bits equal the start column's low bits XOR k.
- R6: Code 3'b111 with `burst_il` = 0 selects page mode. Beat k is (start + k) mod 2^COL_W. The burst runs until it is stopped or restarted, and `beat_last` never asserts in this mode.
- R7: In a fixed-length burst, `beat_last` is high on the final beat and on no other beat.
- R8: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `burst_il` = 1, are reserved. They give a one-beat burst, and `len_err` goes high from that beat on until the next start with a legal code.
- R9: `stop` high with `cke` high and `start` low makes `beat_valid` low in the next cycle. While the block is idle, `stop` has no effect.
- R10: A start during a burst restarts the sequence from the new start column. When `start` and `stop` are both high, the start wins.
- R11: While `cke` is low, `col`, `beat_valid` and `beat_last` hold their values, and `start` and `stop` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes the sequencer |
| start | input | 1 | Capture a new burst |
| stop | input | 1 | Truncate the current burst |
| start_col | input | COL_W | Start column of the burst |
| len_code | input | 3 | Decoded burst-length code |
| burst_il | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_last | output | 1 | Current beat is the final one of a fixed-length burst |
| len_err | output | 1 | Last captured length code was reserved |

## Verification
The bench builds the block with COL_W = 5, which gives a 32-column space. At that size every start column can be combined with every length code and both orderings, and each beat is compared with the arithmetic expected value. The narrow width also lets a page-mode burst run twice around the whole column space in a short run, so the wrap from the top column to zero and the continued absence of a final-beat flag are both observed. Directed sequences then cover the clock-enable freeze, truncation, restart mid-burst, and a start and a stop arriving in the same cycle.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

   // Decoded burst shape captured at the start of a burst
   typedef struct packed {
      logic       page;   // open-ended sequential page burst
      logic       err;    // reserved code seen
      logic [1:0] lg;     // log2 of the fixed burst length
   } burst_shape_t;

   localparam logic [2:0] LEN_1    = 3'b000;
   localparam logic [2:0] LEN_2    = 3'b001;
   localparam logic [2:0] LEN_4    = 3'b010;
   localparam logic [2:0] LEN_8    = 3'b011;
   localparam logic [2:0] LEN_PAGE = 3'b111;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import sdram_burst_pkg::*;
(
   input  logic [2:0]   len_code,
   input  logic         il,
   output burst_shape_t shape
);

   always_comb begin
      shape = '{page: 1'b0, err: 1'b0, lg: 2'd0};
      unique case (len_code)
         LEN_1:    shape.lg = 2'd0;
         LEN_2:    shape.lg = 2'd1;
         LEN_4:    shape.lg = 2'd2;
         LEN_8:    shape.lg = 2'd3;
         LEN_PAGE: begin
            if (il) shape.err  = 1'b1;
            else    shape.page = 1'b1;
         end
         default:  shape.err = 1'b1;
      endcase
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import sdram_burst_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] start_col,
   input  logic             il_in,
   input  burst_shape_t     shape_in,
   output logic [COL_W-1:0] base_q,
   output logic [COL_W-1:0] beat_q,
   output logic [COL_W-1:0] mask_o,
   output logic             il_q,
   output logic             valid_q,
   output logic             last_o,
   output logic             err_q
);

   localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

   burst_shape_t shape_q;

   always_comb begin
      if (shape_q.page) mask_o = '1;
      else              mask_o = (ONE << shape_q.lg) - ONE;
   end

   assign last_o = valid_q && !shape_q.page && (beat_q == mask_o);
   assign err_q  = shape_q.err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         beat_q  <= '0;
         il_q    <= 1'b0;
         valid_q <= 1'b0;
         shape_q <= '{page: 1'b0, err: 1'b0, lg: 2'd0};
      end else if (cke) begin
         if (start) begin
            base_q  <= start_col;
            beat_q  <= '0;
            il_q    <= il_in;
            valid_q <= 1'b1;
            shape_q <= shape_in;
         end else if (stop) begin
            valid_q <= 1'b0;
         end else if (valid_q) begin
            if (last_o) valid_q <= 1'b0;
            else        beat_q  <= beat_q + ONE;
         end
      end
   end

   // R11
   cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> $stable(beat_q) && $stable(valid_q) && $stable(base_q));

   // R9
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && stop && !start |=> !valid_q);

   // R3
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && last_o && !start |=> !valid_q);

   // R6
   page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && start && shape_in.page |=> !last_o);

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  logic             il,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] sum;
   assign sum = base + beat;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      always_comb begin
         if (!mask[i])   col[i] = base[i];
         else if (il)    col[i] = base[i] ^ beat[i];
         else            col[i] = sum[i];
      end
   end

endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
   import sdram_burst_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_code,
   input  logic             burst_il,
   output logic [COL_W-1:0] col,
   output logic             beat_valid,
   output logic             beat_last,
   output logic             len_err
);

   if (COL_W < 4 || COL_W > 16) begin : g_bad_width
      $error("sdram_col_burst_gen: COL_W must lie in 4..16");
   end

   burst_shape_t     shape;
   logic [COL_W-1:0] base_q, beat_q, mask;
   logic             il_q;

   burst_len_decode u_dec (
      .len_code (len_code),
      .il       (burst_il),
      .shape    (shape)
   );

   burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .start     (start),
      .stop      (stop),
      .start_col (start_col),
      .il_in     (burst_il),
      .shape_in  (shape),
      .base_q    (base_q),
      .beat_q    (beat_q),
      .mask_o    (mask),
      .il_q      (il_q),
      .valid_q   (beat_valid),
      .last_o    (beat_last),
      .err_q     (len_err)
   );

   burst_col_map #(.COL_W(COL_W)) u_map (
      .base (base_q),
      .beat (beat_q),
      .mask (mask),
      .il   (il_q),
      .col  (col)
   );

   // R2
   start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && start |=> beat_valid && col == $past(start_col));

   // R8
   reserved_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && start && len_code[2] && !(len_code == 3'b111 && !burst_il)
      |=> len_err && beat_last);

endmodule

// File: tb/sdram_col_burst_gen_tb.sv
module sdram_col_burst_gen_tb;

   localparam int CW   = 5;
   localparam int NCOL = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke = 1'b1, start = 1'b0, stop = 1'b0, burst_il = 1'b0;
   logic [CW-1:0] start_col = '0;
   logic [2:0]    len_code = 3'b000;
   logic [CW-1:0] col;
   logic          beat_valid, beat_last, len_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sdram_col_burst_gen #(.COL_W(CW)) u_dut (
      .clk, .rst_n, .cke, .start, .stop, .start_col, .len_code, .burst_il,
      .col, .beat_valid, .beat_last, .len_err
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected length (0 = page mode) and reserved flag
   function automatic int exp_len(input int code, input bit il);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         7: return il ? 1 : 0;
         default: return 1;
      endcase
   endfunction

   function automatic bit exp_err(input int code, input bit il);
      return (code >= 4 && code <= 6) || (code == 7 && il);
   endfunction

   function automatic int exp_col(input int sc, input int k, input int len, input bit il);
      int m;
      m = (len == 0) ? NCOL - 1 : len - 1;
      if (il) return (sc & ~m) | ((sc ^ k) & m);
      return ((sc & ~m) | ((sc + k) & m)) & (NCOL - 1);
   endfunction

   task automatic run_burst(input int sc, input int code, input bit il);
      int len, n;
      len = exp_len(code, il);
      n = (len == 0) ? 2 * NCOL + 3 : len;
      start = 1'b1; start_col = CW'(sc); len_code = 3'(code); burst_il = il;
      @(negedge clk);
      start = 1'b0;
      chk("R8 err flag", int'(len_err), int'(exp_err(code, il)));
      for (int k = 0; k < n; k++) begin
         chk("R2 valid", int'(beat_valid), 1);
         chk(il ? "R5 il col" : (len == 0 ? "R6 page col" : "R4 seq col"),
             int'(col), exp_col(sc, k, len, il));
         chk(len == 0 ? "R6 no last" : "R7 last", int'(beat_last),
             (len != 0 && k == n - 1) ? 1 : 0);
         @(negedge clk);
      end
      if (len == 0) begin
         stop = 1'b1;
         @(negedge clk);
         stop = 1'b0;
         chk("R9 stop page", int'(beat_valid), 0);
      end else begin
         chk("R3 burst end", int'(beat_valid), 0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 valid", int'(beat_valid), 0);
      chk("R1 last", int'(beat_last), 0);
      chk("R1 err", int'(len_err), 0);
      chk("R1 col", int'(col), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: stop while idle does nothing
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R9 idle stop", int'(beat_valid), 0);

      for (int il = 0; il < 2; il++)
         for (int code = 0; code < 8; code++)
            for (int sc = 0; sc < NCOL; sc++)
               run_burst(sc, code, il[0]);

      // R11: freeze with cke low, start/stop ignored
      start = 1'b1; start_col = 5'd5; len_code = 3'b011; burst_il = 1'b0;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R11 pre", int'(col), 6);
      cke = 1'b0; start = 1'b1; stop = 1'b1; start_col = 5'd20;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R11 hold col", int'(col), 6);
         chk("R11 hold valid", int'(beat_valid), 1);
      end
      cke = 1'b1; start = 1'b0; stop = 1'b0;
      @(negedge clk);
      chk("R11 resume", int'(col), 7);
      @(negedge clk);
      chk("R4 wrap in block", int'(col), 0);

      // R10: restart mid-burst
      start = 1'b1; start_col = 5'd10; len_code = 3'b010; burst_il = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 il beat0", int'(col), 10);
      @(negedge clk);
      chk("R10 il beat1", int'(col), 11);
      start = 1'b1; start_col = 5'd31; len_code = 3'b001; burst_il = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk("R10 restart col", int'(col), 31);
      chk("R10 restart last", int'(beat_last), 0);
      @(negedge clk);
      chk("R10 second beat", int'(col), 30);
      chk("R10 second last", int'(beat_last), 1);
      @(negedge clk);
      chk("R10 ended", int'(beat_valid), 0);

      // R10: start wins over stop
      start = 1'b1; stop = 1'b1; start_col = 5'd3; len_code = 3'b011;
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      chk("R10 start over stop valid", int'(beat_valid), 1);
      chk("R10 start over stop col", int'(col), 3);

      // R9: truncate fixed burst
      @(negedge clk);
      @(negedge clk);
      chk("R9 before stop", int'(col), 5);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R9 truncated valid", int'(beat_valid), 0);
      chk("R9 truncated last", int'(beat_last), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule